// File: doc/BRIEF.md
# Operand Effective-Address Decoder

This block sits in an instruction decode path and turns the addressing bytes that follow an opcode into an operand description. It takes bytes one at a time from a stream, reads the mode/register/rm byte, an optional scale-index-base byte and any displacement, and produces the register field, whether the second operand is a register or memory, the second register number, the computed effective address, the segment to use and the number of bytes it consumed.

A decode begins with a one-cycle `start` pulse. On that pulse the block latches the address-size mode (16-bit or 32-bit), the segment override state and whether the operand is byte-sized. It then asks for bytes with `byteReq` and takes one on every cycle where `byteValid` is also high. General register values are fetched through a single combinational read port on an external register file, one register per cycle. When the result is ready, `done` pulses for one cycle and the outputs hold their values until the next `start`.

Segment numbers are ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. Register numbers are 0..7 = AX, CX, DX, BX, SP, BP, SI, DI (the extended forms in 32-bit mode).

Top module: `ea_decoder`

## Requirements
- R1: The first byte splits as mode = bits 7:6, register field = bits 5:3, rm = bits 2:0. With mode 3, `isMem` is 0, `rmReg` is the rm field and `length` is 1.
- R2: `regField` equals bits 5:3 of the first byte (word operands). This holds in every mode.
- R3: In 32-bit mode, rm 4 with mode not 3 consumes one more byte. In that byte, scale = 1 << bits 7:6, index = bits 5:3 and base = bits 2:0. The address is base + index * scale, and an index field of 4 adds nothing.
- R4: In 32-bit mode with that extra byte, base field 5 and mode 0 use a 4-byte displacement in place of the base register.
- R5: In 32-bit mode, rm 5 with mode 0 is an absolute 4-byte displacement with no register. With mode 1 or 2 the base is register 5 (EBP).
- R6: Mode 1 adds a sign-extended 1-byte displacement. Mode 2 adds a 4-byte displacement in 32-bit mode, or a sign-extended 2-byte displacement in 16-bit mode. Displacement bytes arrive least significant first.
- R7: In 16-bit mode, rm 0..7 address BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX. Only the low 16 bits of each register are used. With mode 0, rm 6 is a 2-byte displacement alone.
- R8: In 16-bit mode, `effAddr` bits 31:16 are zero and bits 15:0 are the sum modulo 2^16.
- R9: Without an override, a memory operand uses SS (2) when its base register is BP/EBP or ESP. Otherwise it uses DS (3). With an override, `segSel` is the latched override number.
- R10: When `byteOp` is latched high, `regField` is {0, bits 4:3} and `regHigh` equals bit 5. For a register operand, `rmReg` is {0, bits 1:0} and `rmHigh` equals bit 2. `rmHigh` is 0 for a memory operand.
- R11: A byte is taken only on a cycle with both `byteReq` and `byteValid` high. `length` equals the number of bytes taken (1 to 6). `done` lasts exactly one cycle. After reset, `done` and `byteReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a decode; configuration inputs are latched |
| addr32 | input | 1 | Address size: 1 = 32-bit, 0 = 16-bit |
| segOvrValid | input | 1 | A segment override prefix is present |
| segOvrSel | input | 3 | Override segment number |
| byteOp | input | 1 | Operand is byte sized |
| byteValid | input | 1 | `byteData` holds a valid stream byte |
| byteData | input | 8 | Stream byte |
| byteReq | output | 1 | Block wants a byte this cycle |
| regRdIdx | output | 3 | Register file read index |
| regRdData | input | 32 | Register file read data (combinational) |
| done | output | 1 | Result valid pulse |
| regField | output | 3 | Register operand number |
| regHigh | output | 1 | Register operand is a high byte |
| isMem | output | 1 | Second operand is memory |
| rmReg | output | 3 | Second register number |
| rmHigh | output | 1 | Second register is a high byte |
| effAddr | output | 32 | Effective address |
| segSel | output | 3 | Segment number for the memory operand |
| length | output | 3 | Addressing bytes consumed |

## Verification
The assertions assume three things about the inputs. `start` arrives only while the block is idle. The register file answers in the same cycle. The configuration inputs may change freely after `start`, because they are latched. The stimulus follows these assumptions: each decode is started from idle and the bench register model responds combinationally. `byteValid` is dropped at random so that requests must be held across gaps, and every stream is exactly as long as its encoding needs. Any extra request therefore stalls and is caught. The random mix covers both address sizes, all mode/rm pairs and override settings, and directed cases cover the no-base, no-index, SS-default and 16-bit wrap forms.

// File: rtl/ea_decoder_pkg.sv
package ea_decoder_pkg;
  localparam int BYTE_W = 8;
  localparam int RNUM_W = 3;
  localparam int SEG_W  = 3;
  localparam int LEN_W  = 3;
  localparam int DCNT_W = 3;

  localparam logic [SEG_W-1:0] SEG_SS = 3'd2;
  localparam logic [SEG_W-1:0] SEG_DS = 3'd3;

  localparam logic [RNUM_W-1:0] RN_BX = 3'd3;
  localparam logic [RNUM_W-1:0] RN_SP = 3'd4;
  localparam logic [RNUM_W-1:0] RN_BP = 3'd5;
  localparam logic [RNUM_W-1:0] RN_SI = 3'd6;
  localparam logic [RNUM_W-1:0] RN_DI = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MODRM, ST_PLAN, ST_SIB, ST_DISP, ST_BASE, ST_INDEX, ST_FINISH
  } decState_t;

  typedef struct packed {
    logic clear;
    logic ldModrm;
    logic ldSib;
    logic ldDisp;
    logic addBase;
    logic addIndex;
  } decStrobe_t;
endpackage

// File: rtl/ea_decoder_ctrl.sv
module ea_decoder_ctrl
  import ea_decoder_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       byteValid,
  input  logic [1:0] modField,
  input  logic [2:0] rmField,
  input  logic       modeAddr32,
  input  logic       dispDone,
  output decStrobe_t stb,
  output logic       byteReq,
  output logic       done
);
  decState_t state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    byteReq   = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        stb.clear = 1'b1;
        nextState = ST_MODRM;
      end
      ST_MODRM: begin
        byteReq = 1'b1;
        if (byteValid) begin
          stb.ldModrm = 1'b1;
          nextState   = ST_PLAN;
        end
      end
      ST_PLAN: begin
        if (modField == 2'd3)                    nextState = ST_FINISH;
        else if (modeAddr32 && rmField == RN_SP) nextState = ST_SIB;
        else                                     nextState = ST_DISP;
      end
      ST_SIB: begin
        byteReq = 1'b1;
        if (byteValid) begin
          stb.ldSib = 1'b1;
          nextState = ST_DISP;
        end
      end
      ST_DISP: begin
        if (dispDone) nextState = ST_BASE;
        else begin
          byteReq = 1'b1;
          if (byteValid) stb.ldDisp = 1'b1;
        end
      end
      ST_BASE: begin
        stb.addBase = 1'b1;
        nextState   = ST_INDEX;
      end
      ST_INDEX: begin
        stb.addIndex = 1'b1;
        nextState    = ST_FINISH;
      end
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  assign done = (state == ST_FINISH);

  // A pending request stays up until a byte is delivered (R11)
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    byteReq && !byteValid |=> byteReq);

  // The result strobe lasts a single cycle (R11)
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/ea_decoder_dp.sv
module ea_decoder_dp
  import ea_decoder_pkg::*;
#(
  parameter int ADDR_W = 32
)(
  input  logic                clk,
  input  logic                rst_n,
  input  decStrobe_t          stb,
  input  logic                done,
  input  logic                addr32,
  input  logic                segOvrValid,
  input  logic [SEG_W-1:0]    segOvrSel,
  input  logic                byteOp,
  input  logic [BYTE_W-1:0]   byteData,
  input  logic [ADDR_W-1:0]   regRdData,
  output logic [RNUM_W-1:0]   regRdIdx,
  output logic [1:0]          modField,
  output logic [2:0]          rmField,
  output logic                modeAddr32,
  output logic                dispDone,
  output logic [RNUM_W-1:0]   regField,
  output logic                regHigh,
  output logic                isMem,
  output logic [RNUM_W-1:0]   rmReg,
  output logic                rmHigh,
  output logic [ADDR_W-1:0]   effAddr,
  output logic [SEG_W-1:0]    segSel,
  output logic [LEN_W-1:0]    length
);
  localparam int HALF_W = ADDR_W / 2;

  logic                cfgAddr32, cfgOvr, cfgByteOp;
  logic [SEG_W-1:0]    cfgOvrSel;
  logic [BYTE_W-1:0]   modrm, sib;
  logic [ADDR_W-1:0]   dispRaw, acc;
  logic [DCNT_W-1:0]   dispCnt, dispLen;
  logic [LEN_W-1:0]    lenCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgAddr32 <= 1'b0;
      cfgOvr    <= 1'b0;
      cfgOvrSel <= '0;
      cfgByteOp <= 1'b0;
      modrm     <= '0;
      sib       <= '0;
      dispRaw   <= '0;
      dispCnt   <= '0;
      acc       <= '0;
      lenCnt    <= '0;
    end else begin
      if (stb.clear) begin
        cfgAddr32 <= addr32;
        cfgOvr    <= segOvrValid;
        cfgOvrSel <= segOvrSel;
        cfgByteOp <= byteOp;
        modrm     <= '0;
        sib       <= '0;
        dispRaw   <= '0;
        dispCnt   <= '0;
        acc       <= '0;
        lenCnt    <= '0;
      end
      if (stb.ldModrm) begin
        modrm  <= byteData;
        lenCnt <= lenCnt + 1'b1;
      end
      if (stb.ldSib) begin
        sib    <= byteData;
        lenCnt <= lenCnt + 1'b1;
      end
      if (stb.ldDisp) begin
        dispRaw[{dispCnt[1:0], 3'b000} +: BYTE_W] <= byteData;
        dispCnt <= dispCnt + 1'b1;
        lenCnt  <= lenCnt + 1'b1;
      end
      if (stb.addBase)  acc <= dispExt + (baseEn ? opnd : '0);
      if (stb.addIndex) acc <= acc + (idxEn ? (opnd << scaleSh) : '0);
    end
  end

  // Field decode from the latched bytes
  logic       hasSib, noBase32, baseEn, idxEn;
  logic [RNUM_W-1:0] baseReg, idxReg;
  logic [1:0] scaleSh;
  logic [ADDR_W-1:0] dispExt, opnd;

  assign modField   = modrm[7:6];
  assign rmField    = modrm[2:0];
  assign modeAddr32 = cfgAddr32;
  assign isMem      = (modField != 2'd3);
  assign hasSib     = cfgAddr32 && isMem && (rmField == RN_SP);
  assign noBase32   = (modField == 2'd0) &&
                      (hasSib ? (sib[2:0] == RN_BP) : (rmField == RN_BP));

  always_comb begin
    dispLen = '0;
    if (modField == 2'd1)      dispLen = 3'd1;
    else if (modField == 2'd2) dispLen = cfgAddr32 ? 3'd4 : 3'd2;
    else if (modField == 2'd0) begin
      if (cfgAddr32 && noBase32)                dispLen = 3'd4;
      else if (!cfgAddr32 && rmField == RN_SI)  dispLen = 3'd2;
    end
  end

  assign dispDone = (dispCnt == dispLen);

  always_comb begin
    unique case (dispLen)
      3'd1:    dispExt = {{(ADDR_W-8){dispRaw[7]}}, dispRaw[7:0]};
      3'd2:    dispExt = {{(ADDR_W-16){dispRaw[15]}}, dispRaw[15:0]};
      3'd4:    dispExt = dispRaw;
      default: dispExt = '0;
    endcase
  end

  always_comb begin
    baseEn  = 1'b0;
    idxEn   = 1'b0;
    baseReg = '0;
    idxReg  = '0;
    scaleSh = 2'd0;
    if (cfgAddr32) begin
      baseEn  = !noBase32;
      baseReg = hasSib ? sib[2:0] : rmField;
      idxEn   = hasSib && (sib[5:3] != RN_SP);
      idxReg  = sib[5:3];
      scaleSh = sib[7:6];
    end else begin
      unique case (rmField)
        3'd0: begin baseEn = 1'b1; baseReg = RN_BX; idxEn = 1'b1; idxReg = RN_SI; end
        3'd1: begin baseEn = 1'b1; baseReg = RN_BX; idxEn = 1'b1; idxReg = RN_DI; end
        3'd2: begin baseEn = 1'b1; baseReg = RN_BP; idxEn = 1'b1; idxReg = RN_SI; end
        3'd3: begin baseEn = 1'b1; baseReg = RN_BP; idxEn = 1'b1; idxReg = RN_DI; end
        3'd4: begin baseEn = 1'b1; baseReg = RN_SI; end
        3'd5: begin baseEn = 1'b1; baseReg = RN_DI; end
        3'd6: begin baseEn = (modField != 2'd0); baseReg = RN_BP; end
        default: begin baseEn = 1'b1; baseReg = RN_BX; end
      endcase
    end
  end

  assign regRdIdx = stb.addIndex ? idxReg : baseReg;
  assign opnd     = cfgAddr32 ? regRdData : {{HALF_W{1'b0}}, regRdData[HALF_W-1:0]};

  // Outputs
  logic defaultSs;
  assign defaultSs = baseEn && ((baseReg == RN_BP) || (cfgAddr32 && baseReg == RN_SP));
  assign segSel    = cfgOvr ? cfgOvrSel : ((isMem && defaultSs) ? SEG_SS : SEG_DS);
  assign effAddr   = cfgAddr32 ? acc : {{HALF_W{1'b0}}, acc[HALF_W-1:0]};
  assign regField  = cfgByteOp ? {1'b0, modrm[4:3]} : modrm[5:3];
  assign regHigh   = cfgByteOp && modrm[5];
  assign rmReg     = (cfgByteOp && !isMem) ? {1'b0, modrm[1:0]} : modrm[2:0];
  assign rmHigh    = cfgByteOp && !isMem && modrm[2];
  assign length    = lenCnt;

  // Register form consumes only the first byte (R1)
  assert_reg_form_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done && !isMem |-> length == 3'd1);

  // Scale-index-base form always consumes at least two bytes (R3)
  assert_sib_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && hasSib |-> length >= 3'd2);

  // Displacement collection finished exactly at its encoded size (R6)
  assert_disp_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> dispCnt == dispLen);

  // Consumed length stays within 1..6 (R11)
  assert_len_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (length >= 3'd1) && (length <= 3'd6));
endmodule

// File: rtl/ea_decoder.sv
module ea_decoder
  import ea_decoder_pkg::*;
#(
  parameter int ADDR_W = 32
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                addr32,
  input  logic                segOvrValid,
  input  logic [SEG_W-1:0]    segOvrSel,
  input  logic                byteOp,
  input  logic                byteValid,
  input  logic [BYTE_W-1:0]   byteData,
  output logic                byteReq,
  output logic [RNUM_W-1:0]   regRdIdx,
  input  logic [ADDR_W-1:0]   regRdData,
  output logic                done,
  output logic [RNUM_W-1:0]   regField,
  output logic                regHigh,
  output logic                isMem,
  output logic [RNUM_W-1:0]   rmReg,
  output logic                rmHigh,
  output logic [ADDR_W-1:0]   effAddr,
  output logic [SEG_W-1:0]    segSel,
  output logic [LEN_W-1:0]    length
);
  decStrobe_t stb;
  logic [1:0] modField;
  logic [2:0] rmField;
  logic       modeAddr32, dispDone;

  ea_decoder_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .byteValid(byteValid),
    .modField(modField), .rmField(rmField), .modeAddr32(modeAddr32),
    .dispDone(dispDone), .stb(stb), .byteReq(byteReq), .done(done)
  );

  ea_decoder_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .done(done), .addr32(addr32),
    .segOvrValid(segOvrValid), .segOvrSel(segOvrSel), .byteOp(byteOp),
    .byteData(byteData), .regRdData(regRdData), .regRdIdx(regRdIdx),
    .modField(modField), .rmField(rmField), .modeAddr32(modeAddr32),
    .dispDone(dispDone), .regField(regField), .regHigh(regHigh),
    .isMem(isMem), .rmReg(rmReg), .rmHigh(rmHigh), .effAddr(effAddr),
    .segSel(segSel), .length(length)
  );
endmodule

// File: tb/test_ea_decoder.sv
`timescale 1ns/1ps
module test_ea_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, addr32 = 1'b0, segOvrValid = 1'b0, byteOp = 1'b0;
  logic [2:0] segOvrSel = '0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic byteReq, done, regHigh, isMem, rmHigh;
  logic [2:0] regRdIdx, regField, rmReg, segSel, length;
  logic [31:0] regRdData, effAddr;
  logic [31:0] regs [8];

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;
  assign regRdData = regs[regRdIdx];

  ea_decoder i_ea_decoder (
    .clk(clk), .rst_n(rst_n), .start(start), .addr32(addr32),
    .segOvrValid(segOvrValid), .segOvrSel(segOvrSel), .byteOp(byteOp),
    .byteValid(byteValid), .byteData(byteData), .byteReq(byteReq),
    .regRdIdx(regRdIdx), .regRdData(regRdData), .done(done),
    .regField(regField), .regHigh(regHigh), .isMem(isMem), .rmReg(rmReg),
    .rmHigh(rmHigh), .effAddr(effAddr), .segSel(segSel), .length(length)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sx8(input logic [7:0] v);
    return {{24{v[7]}}, v};
  endfunction
  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  // One full decode: build stream, model the expected result, run, compare
  task automatic runCase(input bit a32, input bit ovr, input logic [2:0] ovrSel,
                         input bit bop, input logic [7:0] mrm, input logic [7:0] sb,
                         input logic [31:0] dsp);
    logic [7:0] strm [6];
    int n = 1, dl = 0, idx = 0, waitCnt = 0;
    logic [1:0] md = mrm[7:6];
    logic [2:0] rm = mrm[2:0];
    bit useSib = 0, ss = 0;
    logic [31:0] ea = 0, dv = 0;
    string eaTag;
    strm[0] = mrm;
    if (md != 2'd3) begin
      if (a32) begin
        useSib = (rm == 3'd4);
        if (md == 2'd1) dl = 1;
        else if (md == 2'd2) dl = 4;
        else if (useSib ? (sb[2:0] == 3'd5) : (rm == 3'd5)) dl = 4;
      end else begin
        if (md == 2'd1) dl = 1;
        else if (md == 2'd2 || rm == 3'd6) dl = 2;
      end
      dv = (dl == 1) ? sx8(dsp[7:0]) : (dl == 2) ? sx16(dsp[15:0]) : (dl == 4) ? dsp : 32'd0;
      if (a32) begin
        if (useSib) begin
          ea = dv;
          if (!(sb[2:0] == 3'd5 && md == 2'd0)) ea += regs[sb[2:0]];
          if (sb[5:3] != 3'd4) ea += regs[sb[5:3]] << sb[7:6];
          ss = (sb[2:0] == 3'd4) || (sb[2:0] == 3'd5 && md != 2'd0);
          eaTag = (sb[2:0] == 3'd5 && md == 2'd0) ? "R4" : "R3";
        end else if (rm == 3'd5 && md == 2'd0) begin
          ea = dv; eaTag = "R5";
        end else begin
          ea = regs[rm] + dv; ss = (rm == 3'd5);
          eaTag = (rm == 3'd5) ? "R5" : "R6";
        end
      end else begin
        logic [15:0] bx = regs[3][15:0], bp = regs[5][15:0];
        logic [15:0] si = regs[6][15:0], di = regs[7][15:0], s;
        case (rm)
          3'd0: s = bx + si;
          3'd1: s = bx + di;
          3'd2: s = bp + si;
          3'd3: s = bp + di;
          3'd4: s = si;
          3'd5: s = di;
          3'd6: s = (md == 2'd0) ? 16'd0 : bp;
          default: s = bx;
        endcase
        s = s + dv[15:0];
        ea = {16'd0, s};
        ss = (rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6 && md != 2'd0);
        eaTag = (md == 2'd0) ? "R7" : "R6";
      end
      if (useSib) begin strm[n] = sb; n++; end
      for (int k = 0; k < dl; k++) begin strm[n] = dsp[8*k +: 8]; n++; end
    end

    @(negedge clk);
    addr32 = a32; segOvrValid = ovr; segOvrSel = ovrSel; byteOp = bop; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    addr32 = ~a32; segOvrValid = ~ovr; byteOp = ~bop;   // latched: must not matter
    forever begin
      @(negedge clk);
      if (done) break;
      waitCnt++;
      if (waitCnt > 200) begin
        chk("R11 stall", 32'd0, 32'd1);
        break;
      end
      byteValid = (idx < n) && ($urandom_range(3) != 0);
      byteData  = (idx < n) ? strm[idx] : 8'hxx;
      if (byteValid && byteReq) idx++;
    end
    byteValid = 1'b0;

    chk("R11 bytes taken", idx, n);
    chk("R11 length", {29'd0, length}, n);
    chk("R1 isMem", {31'd0, isMem}, {31'd0, md != 2'd3});
    if (bop) begin
      chk("R10 regField", {29'd0, regField}, {30'd0, mrm[4:3]});
      chk("R10 regHigh", {31'd0, regHigh}, {31'd0, mrm[5]});
      chk("R10 rmHigh", {31'd0, rmHigh}, {31'd0, (md == 2'd3) && mrm[2]});
      if (md == 2'd3) chk("R10 rmReg", {29'd0, rmReg}, {30'd0, mrm[1:0]});
    end else begin
      chk("R2 regField", {29'd0, regField}, {29'd0, mrm[5:3]});
      if (md == 2'd3) chk("R1 rmReg", {29'd0, rmReg}, {29'd0, rm});
    end
    if (md != 2'd3) begin
      chk(eaTag, effAddr, ea);
      if (!a32) chk("R8 upper zero", {16'd0, effAddr[31:16]}, 32'd0);
      chk("R9 segSel", {29'd0, segSel}, ovr ? {29'd0, ovrSel} : (ss ? 32'd2 : 32'd3));
    end
    @(negedge clk);
    chk("R11 done pulse", {31'd0, done}, 32'd0);
  endtask

  task automatic randRegs();
    for (int k = 0; k < 8; k++) regs[k] = $urandom;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    randRegs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset done", {31'd0, done}, 32'd0);
    chk("R11 reset byteReq", {31'd0, byteReq}, 32'd0);

    // Directed corner cases
    runCase(1, 0, 0, 0, 8'hD1, 8'h00, 32'h0);          // R1 register form
    runCase(1, 0, 0, 1, 8'hE6, 8'h00, 32'h0);          // R10 high-byte registers
    runCase(1, 0, 0, 0, 8'h05, 8'h00, 32'h12345678);   // R5 absolute
    runCase(1, 0, 0, 0, 8'h45, 8'h00, 32'h000000F0);   // R5 EBP, SS, negative disp8
    runCase(1, 0, 0, 0, 8'h04, 8'hE5, 32'hCAFEF00D);   // R4 no base, index 4 none
    runCase(1, 0, 0, 0, 8'h84, 8'hB4, 32'h80000001);   // R3 ESP base, SS, scale 4
    runCase(1, 3'b1, 3'd4, 0, 8'h44, 8'h24, 32'h7F);   // R9 override beats SS
    runCase(0, 0, 0, 0, 8'h06, 8'h00, 32'h0000BEEF);   // R7 disp16 alone
    runCase(0, 0, 0, 0, 8'h42, 8'h00, 32'h00000080);   // R6 BP+SI with negative disp8
    runCase(0, 0, 0, 0, 8'h87, 8'h00, 32'h0000FFFF);   // R8 wrap
    runCase(0, 0, 0, 1, 8'h3B, 8'h00, 32'h0);          // R10 memory rmHigh 0
    regs[3] = 32'h0001FFFF; regs[6] = 32'h00000003;
    runCase(0, 0, 0, 0, 8'h00, 8'h00, 32'h0);          // R8 BX+SI wraps to 2

    // Constrained random mix
    for (int t = 0; t < 400; t++) begin
      randRegs();
      runCase($urandom_range(1), $urandom_range(3) == 0, 3'($urandom_range(5)),
              $urandom_range(1), 8'($urandom), 8'($urandom), $urandom);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule